// File: doc/BRIEF.md
# Selectable-Rate Majority Glitch Filter

This block cleans up one asynchronous digital input before it reaches a counter or capture stage. The raw input first passes through a flop synchroniser. The synchronised level is then sampled on a strobe from a prescaler. A short chain of stored samples decides the output: the output takes a new level only when every stored sample holds that level. If the samples disagree, the output keeps its previous value.

A 3-bit rate code sets the sample rate. Code 0 turns the filter off, and the synchronised level goes to the output through a single register. Codes 1 to 7 set the divide ratio to 1, 4, 16, 64, 256, 512 or 1024 clocks per sample. A higher ratio rejects wider glitches. It also lowers the highest input frequency that reaches the output. A change of code restarts the prescaler. It also refills the sample chain with the present synchronised level, so the switch does not create a false edge.

Top module: `glitch_vote_filter`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released with the input held low, filt_out is 0.
- R2: With rate_sel = 0 the filter is bypassed: filt_out follows raw_in exactly 3 clock edges later, and a one-clock pulse on raw_in reaches filt_out.
- R3: With rate_sel = 1 a sample is taken every clock, and a level change on raw_in reaches filt_out exactly 6 clock edges later.
- R4: With rate_sel = 2, 3, 4 or 5 the sample spacing is N = 4, 16, 64 or 256 clocks. A held level change reaches filt_out no sooner than 2N+4 and no later than 3N+3 edges after it is applied.
- R5: With rate_sel = 6 or 7 the sample spacing is N = 512 or 1024 clocks, with the same latency bounds as R4.
- R6: For every code other than 0, a pulse on raw_in that lasts 2N clocks or less never changes filt_out.
- R7: For every code other than 0, a pulse on raw_in that lasts 3N clocks always appears on filt_out.
- R8: At a change of rate_sel, every stored sample is reloaded with the synchronised level. If that level has been stable, filt_out equals it 2 edges after the change.
- R9: A change of rate_sel restarts the prescaler. No sample is taken on the change edge, and the first sample is taken N+1 edges after it. After a switch from code 1 to code 2 that coincides with a level change, filt_out changes on edge 14.
- R10: When raw_in is held at the level that filt_out already shows, stepping rate_sel through all eight codes never changes filt_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 1 | Unsynchronised input to be filtered |
| rate_sel | input | 3 | Sample-rate code: 0 bypass, 1..7 divide by 1, 4, 16, 64, 256, 512, 1024 |
| filt_out | output | 1 | Filtered level |

## Verification
The bench uses the default build: two synchroniser flops and three vote stages. With three stages, even the slowest code needs only about three thousand cycles per decision. That makes it affordable to sweep all eight codes in one run, measuring both edge latencies and both glitch-width limits for each code. The bench derives the latency bounds and pulse widths from the stage counts and the ratio table. The exact cases (bypass, divide by one, the restart after a code change, and the reload) are checked on single edges.

// File: rtl/gvf_pkg.sv
package gvf_pkg;
    localparam int CODE_W    = 3;
    localparam int MAX_RATIO = 1024;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    typedef logic [CODE_W-1:0] rate_code_t;

    localparam rate_code_t CODE_BYPASS = 3'd0;

    // Clocks per sample for each code; 0 marks the bypass code.
    function automatic int unsigned ratio_of(rate_code_t code);
        int unsigned r;
        case (code)
            3'd1:    r = 1;
            3'd2:    r = 4;
            3'd3:    r = 16;
            3'd4:    r = 64;
            3'd5:    r = 256;
            3'd6:    r = 512;
            3'd7:    r = 1024;
            default: r = 0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/gvf_sync.sv
module gvf_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.chain[DEPTH-1];
endmodule

// File: rtl/gvf_prescaler.sv
module gvf_prescaler
    import gvf_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rate_code_t cfg,
    input  logic       restart,
    output logic       samp_en
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_state_t;

    pre_state_t   st_d, st_q;
    logic [W-1:0] term;
    logic         active;

    always_comb begin
        active  = (cfg != CODE_BYPASS);
        term    = W'(ratio_of(cfg) - 32'd1);
        samp_en = active && !restart && (st_q.cnt == term);

        st_d = st_q;
        if (restart || !active) st_d.cnt = '0;
        else if (samp_en)       st_d.cnt = '0;
        else                    st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gvf_vote.sv
module gvf_vote #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             reload,
    input  logic             samp_en,
    input  logic             level,
    output logic             filt,
    output logic [DEPTH-1:0] samples
);
    typedef struct packed {
        logic [DEPTH-1:0] smp;
        logic             out;
    } vote_state_t;

    vote_state_t st_d, st_q;
    logic        all_hi, all_lo;

    always_comb begin
        all_hi = &st_q.smp;
        all_lo = ~|st_q.smp;

        st_d = st_q;
        if (reload)       st_d.smp = {DEPTH{level}};
        else if (samp_en) st_d.smp = {st_q.smp[DEPTH-2:0], level};

        if (bypass)      st_d.out = level;
        else if (all_hi) st_d.out = 1'b1;
        else if (all_lo) st_d.out = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt    = st_q.out;
    assign samples = st_q.smp;
endmodule

// File: rtl/glitch_vote_filter.sv
module glitch_vote_filter
    import gvf_pkg::*;
#(
    parameter int SYNC_DEPTH = 2,
    parameter int VOTE_DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic [2:0] rate_sel,
    output logic       filt_out
);
    typedef struct packed {
        rate_code_t cfg;
    } top_state_t;

    top_state_t            st_d, st_q;
    rate_code_t            cfg_now;
    logic                  code_change;
    logic                  sync_lvl;
    logic                  samp_en;
    logic [VOTE_DEPTH-1:0] vote_smp;

    always_comb begin
        code_change = (rate_sel != st_q.cfg);
        st_d        = st_q;
        st_d.cfg    = rate_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_now = st_q.cfg;

    gvf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .level    (sync_lvl)
    );

    gvf_prescaler #(.W(CNT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_now),
        .restart (code_change),
        .samp_en (samp_en)
    );

    gvf_vote #(.DEPTH(VOTE_DEPTH)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (cfg_now == CODE_BYPASS),
        .reload  (code_change),
        .samp_en (samp_en),
        .level   (sync_lvl),
        .filt    (filt_out),
        .samples (vote_smp)
    );
endmodule

// File: rtl/gvf_checker.sv
module gvf_checker #(
    parameter int VOTE_DEPTH = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            rate_sel,
    input logic [2:0]            cfg_now,
    input logic                  sync_lvl,
    input logic                  samp_en,
    input logic [VOTE_DEPTH-1:0] vote_smp,
    input logic                  filt_out
);
    a_r2_bypass_tracks_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_now == 3'd0) |=> (filt_out == $past(sync_lvl)));

    a_r2_bypass_no_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_now == 3'd0) |-> !samp_en);

    a_r3_div1_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_now == 3'd1 && rate_sel == 3'd1) |-> samp_en);

    a_r4_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && cfg_now >= 3'd2 && rate_sel == cfg_now) |=> !samp_en);

    a_r9_no_sample_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != cfg_now) |-> !samp_en);

    a_r8_reload_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != cfg_now) |=>
            ($countones(vote_smp) == 0 || $countones(vote_smp) == VOTE_DEPTH));

    a_r6_hold_on_split_vote: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_now != 3'd0 && $countones(vote_smp) != 0 &&
         $countones(vote_smp) != VOTE_DEPTH) |=> $stable(filt_out));
endmodule

bind glitch_vote_filter gvf_checker #(.VOTE_DEPTH(VOTE_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .cfg_now  (cfg_now),
    .sync_lvl (sync_lvl),
    .samp_en  (samp_en),
    .vote_smp (vote_smp),
    .filt_out (filt_out)
);

// File: tb/glitch_vote_filter_test.sv
module glitch_vote_filter_test;
    localparam int S = 2;
    localparam int V = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_in = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       filt_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    glitch_vote_filter #(.SYNC_DEPTH(S), .VOTE_DEPTH(V)) uut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
        .rate_sel(rate_sel), .filt_out(filt_out)
    );

    always #2 clk = ~clk;

    function automatic int ratio(int c);
        if (c == 0) return 0;
        if (c <= 5) return 1 << (2 * (c - 1));
        return (c == 6) ? 512 : 1024;
    endfunction

    function automatic string tag_of(int c);
        if (c == 0) return "R2";
        if (c == 1) return "R3";
        if (c <= 5) return "R4";
        return "R5";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic latency(logic lvl, int limit, output int lat);
        raw_in = lvl;
        lat = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            lat++;
            if (filt_out == lvl) break;
        end
    endtask

    // pulse of width w at level ~base; returns whether filt_out left base
    task automatic pulse(logic base, int w, int span, output bit saw);
        saw = 1'b0;
        raw_in = ~base;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk);
            if (i == w) raw_in = base;
            if (filt_out != base) saw = 1'b1;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int lat, n, hold, lo, hi;
        bit saw;

        // R1 reset
        wait_cycles(4);
        check(filt_out == 1'b0, "R1", "out during reset", filt_out, 0);
        rst_n = 1'b1;
        wait_cycles(10);
        check(filt_out == 1'b0, "R1", "out after reset", filt_out, 0);

        for (int c = 0; c < 8; c++) begin
            n    = ratio(c);
            hold = (V + 1) * (n > 0 ? n : 1) + 12;
            rate_sel = 3'(c);
            raw_in   = 1'b0;
            wait_cycles(hold);
            check(filt_out == 1'b0, tag_of(c), "settled low", filt_out, 0);

            if (c == 0) begin lo = S + 1; hi = S + 1; end
            else begin lo = (V - 1) * n + S + 2; hi = V * n + S + 1; end

            latency(1'b1, hi + 10, lat);
            check(lat >= lo && lat <= hi, tag_of(c), "rise latency", lat, hi);
            wait_cycles(hold);
            latency(1'b0, hi + 10, lat);
            check(lat >= lo && lat <= hi, tag_of(c), "fall latency", lat, hi);
            wait_cycles(hold);

            if (c == 0) begin
                pulse(1'b0, 1, 8, saw);
                check(saw, "R2", "bypass 1-clock pulse seen", saw, 1);
            end else begin
                pulse(1'b0, (V - 1) * n, (V + 1) * n + S + 6, saw);
                check(!saw, "R6", "widest rejected glitch", saw, 0);
                wait_cycles(hold);
                pulse(1'b0, V * n, (V + 1) * n + S + 6, saw);
                check(saw, "R7", "narrowest passed pulse", saw, 1);
                wait_cycles(hold);
                check(filt_out == 1'b0, "R7", "back low after pulse", filt_out, 0);
            end
        end

        // R8: reload on code change
        rate_sel = 3'd7;
        raw_in   = 1'b0;
        wait_cycles(4 * 1024 + 12);
        raw_in = 1'b1;
        wait_cycles(10);
        check(filt_out == 1'b0, "R8", "slow code still low", filt_out, 0);
        rate_sel = 3'd1;
        @(negedge clk);
        check(filt_out == 1'b0, "R8", "edge 1 after change", filt_out, 0);
        @(negedge clk);
        check(filt_out == 1'b1, "R8", "edge 2 after change", filt_out, 1);

        // R10: steady low, sweep codes
        rate_sel = 3'd3;
        raw_in   = 1'b0;
        wait_cycles(4 * 16 + 12);
        for (int c = 0; c < 8; c++) begin
            saw = 1'b0;
            rate_sel = 3'(c);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (filt_out != 1'b0) saw = 1'b1;
            end
            check(!saw, "R10", "steady low through code sweep", saw, 0);
        end
        rate_sel = 3'd1;
        raw_in   = 1'b1;
        wait_cycles(20);
        for (int c = 7; c >= 0; c--) begin
            saw = 1'b0;
            rate_sel = 3'(c);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (filt_out != 1'b1) saw = 1'b1;
            end
            check(!saw, "R10", "steady high through code sweep", saw, 0);
        end

        // R9: prescaler restart, code 1 -> 2 with simultaneous fall
        rate_sel = 3'd1;
        raw_in   = 1'b1;
        wait_cycles(20);
        rate_sel = 3'd2;
        raw_in   = 1'b0;
        wait_cycles(13);
        check(filt_out == 1'b1, "R9", "still high at edge 13", filt_out, 1);
        @(negedge clk);
        check(filt_out == 1'b0, "R9", "low at edge 14", filt_out, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule